// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and presents one interrupt to a processor as a priority level plus a vector number. Each request is sampled into a pending register every clock. A source can win only if it is pending, enabled and unmasked. Software enables a source by giving it a nonzero 8-bit priority level, and blocks it by setting its bit in a 64-bit mask. A comparison tree picks the active source with the highest level and turns its index into a vector. The level and vector are then registered and driven to the processor.

Software reaches the block through a single-cycle read/write port that decodes a 256-byte window. A read returns data in the same cycle. A write takes effect at the clock edge that samples it. One read-only location returns the vector currently being presented, so polling code can find the winning source without a hardware acknowledge cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source n is active when its pending bit (or its force bit, which is always zero here) is 1, its enable bit is 1 and its mask bit is 0.
- R2: Among active sources, the one with the greatest level wins. When levels are equal, the higher source index wins.
- R3: When a source wins, `cpu_vector` is 64 plus the winner's index and `cpu_level` is the winner's level. With no active source, `cpu_vector` is 24 and `cpu_level` is 0.
- R4: `cpu_level` and `cpu_vector` are registered. A change to pending, mask, enable or level state made at one clock edge appears on them at the following edge.
- R5: During reset, all mask bits are set to 1. Pending bits, enable bits and all level bytes are cleared, `cpu_level` is 0, `cpu_vector` is 24 and `bus_err` is 0.
- R6: A write to byte offset 0x40+n (n = 0..63) stores `bus_wdata[7:0]` as the level of source n. The source's enable bit is set if that byte is nonzero and cleared if it is zero. A read of the same offset returns the level in bits 7:0, with zeros above.
- R7: Offset 0x08 holds mask bits 63:32 and offset 0x0C holds mask bits 31:0. Both are readable and writable, and a mask bit of 1 blocks its source.
- R8: Offset 0x00 reads pending bits 63:32 and offset 0x04 reads pending bits 31:0. Each pending bit equals the value its request input had at the previous clock edge. Writes to these offsets do not change the pending bits.
- R9: Reads return data combinationally while `bus_sel` is 1 and `bus_wr` is 0. Offset 0xE0 returns the present `cpu_vector` in bits 7:0. Offsets 0x10 and 0x14 (force words) return zero, as does every unmapped offset. `bus_rdata` is zero when no read is in progress.
- R10: A write to any offset other than 0x08, 0x0C or 0x40..0x7F raises `bus_err` for exactly the one cycle after the write edge. Such a write changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 64 | Level-sensitive request lines, bit n for source n |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | One-cycle flag for a write to a non-writable offset |
| cpu_level | output | 8 | Level of the presented interrupt, 0 when idle |
| cpu_vector | output | 8 | Vector of the presented interrupt, 24 when idle |

## Verification
The assertions check several properties on every cycle: that the idle level and the idle vector always appear together, that the vector stays in its legal range, that the pending bits track the request lines one cycle late, that the presented source was unmasked in the cycle it was chosen, and that the error flag is raised only by writes. Other behaviours can be shown only by the bench scenarios, which a behavioural model scores every cycle. These are the level ordering, ties broken toward the higher index, enables tied to zero and nonzero level writes, the one-edge latency of a mask or level change, and the read values of each offset.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NSRC   = 64;
    localparam int WORD_W = 32;
    localparam int LVLW   = 8;
    localparam int IDXW   = $clog2(NSRC);
    localparam int VECW   = 8;
    localparam int ADDRW  = 8;

    // Fixed byte offsets of the register window
    localparam logic [ADDRW-1:0] OFS_PEND_HI  = 8'h00;
    localparam logic [ADDRW-1:0] OFS_PEND_LO  = 8'h04;
    localparam logic [ADDRW-1:0] OFS_MASK_HI  = 8'h08;
    localparam logic [ADDRW-1:0] OFS_MASK_LO  = 8'h0C;
    localparam logic [ADDRW-1:0] OFS_FORCE_HI = 8'h10;
    localparam logic [ADDRW-1:0] OFS_FORCE_LO = 8'h14;
    localparam logic [ADDRW-1:0] OFS_VECTOR   = 8'hE0;
    localparam logic [1:0]       LVL_WIN_TAG  = 2'b01;  // 0x40..0x7F

    typedef enum logic [3:0] {
        RK_NONE,
        RK_PEND_HI,
        RK_PEND_LO,
        RK_MASK_HI,
        RK_MASK_LO,
        RK_FORCE_HI,
        RK_FORCE_LO,
        RK_LEVEL,
        RK_VECTOR
    } reg_kind_e;

    typedef struct packed {
        logic            valid;
        logic [LVLW-1:0] lvl;
        logic [IDXW-1:0] idx;
    } cand_t;

    function automatic reg_kind_e decode_ofs(input logic [ADDRW-1:0] a);
        reg_kind_e k;
        if (a[ADDRW-1 -: 2] == LVL_WIN_TAG) begin
            k = RK_LEVEL;
        end else begin
            unique case (a)
                OFS_PEND_HI:  k = RK_PEND_HI;
                OFS_PEND_LO:  k = RK_PEND_LO;
                OFS_MASK_HI:  k = RK_MASK_HI;
                OFS_MASK_LO:  k = RK_MASK_LO;
                OFS_FORCE_HI: k = RK_FORCE_HI;
                OFS_FORCE_LO: k = RK_FORCE_LO;
                OFS_VECTOR:   k = RK_VECTOR;
                default:      k = RK_NONE;
            endcase
        end
        return k;
    endfunction

    // lo covers lower source indices, hi covers higher ones; equal levels go to hi
    function automatic cand_t pick_cand(input cand_t lo, input cand_t hi);
        if (hi.valid && (!lo.valid || hi.lvl >= lo.lvl)) return hi;
        return lo;
    endfunction

endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]    active,
    input  logic [LVLW-1:0] lvl [N],
    output cand_t           winner
);
    localparam int STAGES = $clog2(N);

    for (genvar s = 0; s <= STAGES; s++) begin : g_stage
        localparam int W = N >> s;
        cand_t nd [W];
        if (s == 0) begin : g_leaf
            for (genvar j = 0; j < W; j++) begin : g_j
                assign nd[j] = '{valid: active[j], lvl: lvl[j], idx: IDXW'(j)};
            end
        end else begin : g_node
            for (genvar j = 0; j < W; j++) begin : g_j
                assign nd[j] = pick_cand(g_stage[s-1].nd[2*j], g_stage[s-1].nd[2*j+1]);
            end
        end
    end

    assign winner = g_stage[STAGES].nd[0];

endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    irq_req,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDRW-1:0]   bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic [VECW-1:0]    cur_vector,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               bus_err,
    output logic [NSRC-1:0]    pend_q,
    output logic [NSRC-1:0]    mask_q,
    output logic [NSRC-1:0]    en_q,
    output logic [LVLW-1:0]    lvl_q [NSRC]
);
    reg_kind_e       kind;
    logic [IDXW-1:0] lidx;
    logic            err_q;

    assign kind = decode_ofs(bus_addr);
    assign lidx = bus_addr[IDXW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '1;
            en_q   <= '0;
            err_q  <= 1'b0;
            for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
        end else begin
            pend_q <= irq_req;
            err_q  <= 1'b0;
            if (bus_sel && bus_wr) begin
                unique case (kind)
                    RK_MASK_HI: mask_q[NSRC-1:WORD_W] <= bus_wdata;
                    RK_MASK_LO: mask_q[WORD_W-1:0]    <= bus_wdata;
                    RK_LEVEL: begin
                        lvl_q[lidx] <= bus_wdata[LVLW-1:0];
                        en_q[lidx]  <= |bus_wdata[LVLW-1:0];
                    end
                    default:    err_q <= 1'b1;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (kind)
                RK_PEND_HI: bus_rdata = pend_q[NSRC-1:WORD_W];
                RK_PEND_LO: bus_rdata = pend_q[WORD_W-1:0];
                RK_MASK_HI: bus_rdata = mask_q[NSRC-1:WORD_W];
                RK_MASK_LO: bus_rdata = mask_q[WORD_W-1:0];
                RK_LEVEL:   bus_rdata = WORD_W'(lvl_q[lidx]);
                RK_VECTOR:  bus_rdata = WORD_W'(cur_vector);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign bus_err = err_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int IDLE_VEC = 24,
    parameter int VEC_BASE = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       irq_req,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [7:0]        cpu_level,
    output logic [7:0]        cpu_vector
);
    localparam logic [NSRC-1:0] FORCE_NONE = '0;
    localparam logic [VECW-1:0] IDLE_V     = VECW'(IDLE_VEC);
    localparam logic [VECW-1:0] BASE_V     = VECW'(VEC_BASE);

    logic [NSRC-1:0] pend_w, mask_w, en_w, active_w;
    logic [LVLW-1:0] lvl_w [NSRC];
    cand_t           win_w;
    logic [LVLW-1:0] level_q;
    logic [VECW-1:0] vector_q;

    pic_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .irq_req    (irq_req),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cur_vector (vector_q),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .pend_q     (pend_w),
        .mask_q     (mask_w),
        .en_q       (en_w),
        .lvl_q      (lvl_w)
    );

    assign active_w = (pend_w | FORCE_NONE) & en_w & ~mask_w;

    pic_arbiter #(.N(NSRC)) u_arb (
        .active (active_w),
        .lvl    (lvl_w),
        .winner (win_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= '0;
            vector_q <= IDLE_V;
        end else if (win_w.valid) begin
            level_q  <= win_w.lvl;
            vector_q <= BASE_V + VECW'(win_w.idx);
        end else begin
            level_q  <= '0;
            vector_q <= IDLE_V;
        end
    end

    assign cpu_level  = level_q;
    assign cpu_vector = vector_q;

endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
#(
    parameter int IDLE_VEC = 24,
    parameter int VEC_BASE = 64
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] irq_req,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [7:0]      bus_addr,
    input logic            bus_err,
    input logic [7:0]      cpu_level,
    input logic [7:0]      cpu_vector,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] mask
);
    logic [NSRC-1:0] mask_prev;
    always_ff @(posedge clk) mask_prev <= mask;

    a_r5_reset_outputs: assert property (@(posedge clk)
        rst |=> (cpu_level == 8'd0 && cpu_vector == 8'(IDLE_VEC) && !bus_err));

    a_r5_reset_mask: assert property (@(posedge clk)
        rst |=> (&mask));

    a_r3_idle_pairing: assert property (@(posedge clk) disable iff (rst)
        (cpu_level == 8'd0) == (cpu_vector == 8'(IDLE_VEC)));

    a_r3_vector_range: assert property (@(posedge clk) disable iff (rst)
        (cpu_vector == 8'(IDLE_VEC)) ||
        (cpu_vector >= 8'(VEC_BASE) && cpu_vector < 8'(VEC_BASE + NSRC)));

    // R7: a presented source was unmasked when it was chosen
    a_r7_masked_never_wins: assert property (@(posedge clk) disable iff (rst)
        (cpu_level != 8'd0) |-> !mask_prev[cpu_vector[IDXW-1:0]]);

    a_r8_pending_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pend == $past(irq_req)));

    a_r10_err_needs_write: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_sel && bus_wr));

    a_r10_pend_write_flags: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 8'h00) |=> bus_err);

endmodule

bind prio_irq_ctrl pic_checker #(.IDLE_VEC(IDLE_VEC), .VEC_BASE(VEC_BASE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_err    (bus_err),
    .cpu_level  (cpu_level),
    .cpu_vector (cpu_vector),
    .pend       (pend_w),
    .mask       (mask_w)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  cpu_level;
    logic [7:0]  cpu_vector;

    always #4 clk = ~clk;  // 125 MHz

    prio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_req = "R5";

    // behavioural reference state
    int          m_lvl [64];
    bit [63:0]   m_mask, m_en, m_pend;
    int          exp_level, exp_vec;
    bit          exp_err;

    always @(posedge clk) begin
        if (rst) begin
            m_mask = '1; m_en = '0; m_pend = '0;
            foreach (m_lvl[i]) m_lvl[i] = 0;
            exp_level = 0; exp_vec = 24; exp_err = 0;
        end else begin
            int best, bl;
            best = -1; bl = 0;
            for (int i = 0; i < 64; i++)
                if (m_pend[i] && m_en[i] && !m_mask[i] && m_lvl[i] >= bl) begin
                    bl = m_lvl[i]; best = i;
                end
            exp_level = (best < 0) ? 0 : bl;
            exp_vec   = (best < 0) ? 24 : 64 + best;
            exp_err   = 0;
            if (bus_sel && bus_wr) begin
                if (bus_addr == 8'h08) m_mask[63:32] = bus_wdata;
                else if (bus_addr == 8'h0C) m_mask[31:0] = bus_wdata;
                else if (bus_addr >= 8'h40 && bus_addr < 8'h80) begin
                    m_lvl[bus_addr - 8'h40] = int'(bus_wdata[7:0]);
                    m_en[bus_addr - 8'h40]  = (bus_wdata[7:0] != 0);
                end else exp_err = 1;
            end
            m_pend = irq_req;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a >= 8'h40 && a < 8'h80) return 32'(m_lvl[a - 8'h40]);
        case (a)
            8'h00: return m_pend[63:32];
            8'h04: return m_pend[31:0];
            8'h08: return m_mask[63:32];
            8'h0C: return m_mask[31:0];
            8'hE0: return 32'(exp_vec);
            default: return 32'd0;
        endcase
    endfunction

    // per-cycle comparison of the registered outputs
    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_vec++;
            if (cpu_level !== 8'(exp_level) || cpu_vector !== 8'(exp_vec) || bus_err !== exp_err) begin
                n_bad++;
                $display("FAIL %s: level/vector/err = %0d/%0d/%0b, expected %0d/%0d/%0b",
                         cur_req, cpu_level, cpu_vector, bus_err, exp_level, exp_vec, exp_err);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bus_sel = 0; bus_wr = 0;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        e = model_read(a);
        n_vec++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s: read 0x%02h = 0x%08h, expected 0x%08h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R5 reset state
        cur_req = "R5";
        rd(8'h08, "R5 mask hi");
        rd(8'h0C, "R5 mask lo");
        rd(8'h45, "R5 level");
        rd(8'hE0, "R5 vector");
        // R1 R3: pending but not enabled -> idle
        cur_req = "R1";
        irq_req = 64'h0000_0001_0000_0010;
        idle(2);
        rd(8'h00, "R8 pend hi");
        rd(8'h04, "R8 pend lo");
        // R6 enable via level write, R7 unmask
        cur_req = "R6";
        wr(8'h44, 32'h0000_0003);
        rd(8'h44, "R6 level readback");
        cur_req = "R7";
        wr(8'h0C, 32'hFFFF_FFEF);
        rd(8'h0C, "R7 mask lo");
        // R4: new winner shows one edge after the mask write
        cur_req = "R4";
        idle(2);
        rd(8'hE0, "R9 vector read");
        // R2 higher level wins
        cur_req = "R2";
        wr(8'h60, 32'h0000_0009);
        wr(8'h08, 32'hFFFF_FFFE);
        idle(3);
        // R2 tie: source 4 raised to 9, source 32 still wins
        wr(8'h44, 32'h0000_0009);
        idle(3);
        // R6 zero low byte disables source 32
        cur_req = "R6";
        wr(8'h60, 32'h0000_0100);
        idle(3);
        rd(8'h60, "R6 zero level readback");
        // R10 pending write ignored and flagged
        cur_req = "R10";
        wr(8'h04, 32'hFFFF_FFFF);
        idle(1);
        rd(8'h04, "R8 pend unchanged");
        wr(8'h10, 32'h1);
        wr(8'h33, 32'h1);
        idle(2);
        // R9 force words and unmapped reads
        cur_req = "R9";
        rd(8'h10, "R9 force hi");
        rd(8'h14, "R9 force lo");
        rd(8'h20, "R9 unmapped");
        rd(8'hE4, "R9 unmapped");
        irq_req = '0;
        idle(3);
        rd(8'hE0, "R3 idle vector");
        // mixed random traffic against the model
        cur_req = "R1 R2 R3 R4 R6 R7 R8";
        for (int c = 0; c < 3000; c++) begin
            int op;
            @(negedge clk);
            irq_req = {$urandom, $urandom} & {$urandom, $urandom};
            op = $urandom_range(0, 7);
            bus_sel = 0; bus_wr = 0;
            if (op == 0) begin
                bus_sel = 1; bus_wr = 1; bus_addr = 8'h40 + 8'($urandom_range(0, 63));
                bus_wdata = ($urandom_range(0, 3) == 0) ? 32'h0 : 32'($urandom_range(1, 4));
            end else if (op == 1) begin
                bus_sel = 1; bus_wr = 1; bus_addr = $urandom_range(0, 1) ? 8'h08 : 8'h0C;
                bus_wdata = $urandom & $urandom;
            end else if (op == 2) begin
                bus_sel = 1; bus_wr = 0;
                bus_addr = 8'($urandom_range(0, 3) * 4);
                if ($urandom_range(0, 1) == 1) bus_addr = 8'hE0;
                #1;
                n_vec++;
                if (bus_rdata !== model_read(bus_addr)) begin
                    n_bad++;
                    $display("FAIL R9: read 0x%02h = 0x%08h, expected 0x%08h",
                             bus_addr, bus_rdata, model_read(bus_addr));
                end
            end
        end
        idle(3);
        finish_run();
    end

endmodule